// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block drives a successive-approximation analog-to-digital converter across a set of channels. A per-channel enable mask selects the channels. On each channel it holds the sample/hold control for one clock, then spends one clock on each result bit. It presents a trial code to an external DAC and keeps or drops the trial bit according to the comparator it reads back. Finished codes go into per-channel result registers, which a simple read port drains. The read port reports whether each result is fresh and whether an unread value was overwritten.

A scan starts on a software pulse or on one of three hardware sources: a rising edge on a synchronised external pin, a timer event and a PWM event. Each hardware source has its own enable. The mode input selects one of three behaviours. Single mode converts one channel. Scan mode converts every enabled channel once in ascending index order. Continuous mode repeats the scan until a stop request arrives. A sticky end-of-conversion flag marks the end of each scan, and an interrupt output follows that flag when the interrupt is enabled.

Top module: `adc_scan_seq`

## Requirements
- R1: Conversion is RES bits (default 12), decided most significant bit first. A trial bit is kept when the comparator input is 1, which means the input is at or above `dac_code_o`. When the comparator follows an input value V in 0..4095, the stored result equals V.
- R2: Each channel gets exactly one clock with `sample_o` high, then RES conversion clocks. The first trial code after sampling is 0x800, with only the MSB set. A lone channel therefore keeps `busy_o` high for 13 clocks, and a scan of k channels keeps it high for 13·k clocks.
- R3: `chan_mask_i` bit i enables channel i, for channels 0..11. Scan mode (`mode_i`=1) converts each enabled channel once, from the lowest index to the highest.
- R4: Single mode (`mode_i`=0, and also the unused code 3) converts only the lowest enabled channel, once.
- R5: Continuous mode (`mode_i`=2) restarts the scan at the lowest enabled channel after the highest one, and repeats until `stop_i`.
- R6: `sw_start_i` always starts a scan. `hw_trig_en_i` gates the other sources: bit 0 the rising edge of `ext_start_i` (after a two-stage synchroniser), bit 1 `tmr_evt_i`, bit 2 `pwm_trig_i`. A disabled source starts nothing.
- R7: A trigger that arrives while `busy_o` is high is ignored. A trigger with an all-zero mask starts no conversion.
- R8: `eoc_o` is 0 after reset. It sets when the last channel of a scan, or the single conversion, finishes. It stays set until a clock with `eoc_clr_i`=1. `irq_o` is `eoc_o` gated by `int_en_i`.
- R9: A finished conversion sets the channel's valid bit. A read (`rd_en_i` with `rd_ch_i`) clears valid and overrun. A write to a channel that is still valid sets its overrun bit. All bits are 0 after reset.
- R10: `stop_i` returns the sequencer to idle on the next clock. It writes no result for the channel in progress and does not set `eoc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 0 single, 1 scan, 2 continuous, 3 as single |
| chan_mask_i | input | NCH | Channel enables, bit i for channel i |
| sw_start_i | input | 1 | Software start pulse |
| ext_start_i | input | 1 | External start pin, rising edge |
| tmr_evt_i | input | 1 | Timer event pulse |
| pwm_trig_i | input | 1 | PWM trigger pulse |
| hw_trig_en_i | input | 3 | Enables for pin, timer, PWM |
| stop_i | input | 1 | Abort / end continuous mode |
| cmp_i | input | 1 | Comparator: input at or above trial code |
| dac_code_o | output | RES | Trial code to the DAC |
| sample_o | output | 1 | Sample/hold control |
| busy_o | output | 1 | Sequencer active |
| cur_ch_o | output | CHW | Channel being sampled/converted |
| rd_en_i | input | 1 | Read strobe, clears valid/overrun |
| rd_ch_i | input | CHW | Channel to read |
| rd_data_o | output | RES | Result of the read channel |
| rd_valid_o | output | 1 | Result unread since written |
| rd_ovr_o | output | 1 | Result overwritten while unread |
| eoc_clr_i | input | 1 | Write-one clear of the end flag |
| int_en_i | input | 1 | Interrupt enable |
| eoc_o | output | 1 | End-of-conversion flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: twelve channels, 12-bit resolution and a two-stage pin synchroniser. With these values the highest channel index 11 can take part in scans and in the continuous-mode wrap to the lowest channel. Both ends of the code range, 0 and 4095, can be placed on a channel. The pin trigger is also exercised through its full synchroniser latency. The bench models the comparator as a stored input value for each channel compared against the trial code. The expected result is then that value itself, and the expected scan order and busy time follow from the mask alone.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

   typedef enum logic [1:0] {
      MODE_SINGLE = 2'd0,
      MODE_SCAN   = 2'd1,
      MODE_CONT   = 2'd2,
      MODE_RSVD   = 2'd3
   } scan_mode_e;

   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_SAMPLE = 2'd1,
      SQ_CONV   = 2'd2
   } seq_state_e;

endpackage

// File: rtl/adcseq_trig.sv
// Trigger combiner: software start, synchronised pin edge, timer and PWM events.
module adcseq_trig #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sw_start_i,
   input  logic       ext_pin_i,
   input  logic       tmr_evt_i,
   input  logic       pwm_trig_i,
   input  logic [2:0] hw_en_i,
   output logic       fire_o
);

   logic ext_s;
   logic ext_d;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign ext_s = ext_pin_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '0;
            end else begin
               sh_q[0] <= ext_pin_i;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  sh_q[i] <= sh_q[i-1];
               end
            end
         end
         assign ext_s = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ext_d <= 1'b0;
      else        ext_d <= ext_s;
   end

   logic ext_rise;
   assign ext_rise = ext_s & ~ext_d;

   assign fire_o = sw_start_i
                 | (hw_en_i[0] & ext_rise)
                 | (hw_en_i[1] & tmr_evt_i)
                 | (hw_en_i[2] & pwm_trig_i);

endmodule

// File: rtl/adcseq_pick.sv
// Channel picker: lowest enabled channel, and lowest enabled channel above the current one.
module adcseq_pick #(
   parameter int NCH = 12,
   parameter int CHW = 4
) (
   input  logic [NCH-1:0] mask_i,
   input  logic [CHW-1:0] cur_ch_i,
   output logic [CHW-1:0] first_ch_o,
   output logic           first_vld_o,
   output logic [CHW-1:0] next_ch_o,
   output logic           next_vld_o
);

   logic [NCH-1:0] above;

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_above
         assign above[g] = mask_i[g] && (CHW'(g) > cur_ch_i);
      end
   endgenerate

   always_comb begin
      first_ch_o  = '0;
      first_vld_o = 1'b0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (mask_i[i]) begin
            first_ch_o  = CHW'(i);
            first_vld_o = 1'b1;
         end
      end
   end

   always_comb begin
      next_ch_o  = '0;
      next_vld_o = 1'b0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (above[i]) begin
            next_ch_o  = CHW'(i);
            next_vld_o = 1'b1;
         end
      end
   end

endmodule

// File: rtl/adcseq_sar.sv
// Successive-approximation loop: one bit decided per clock, MSB first.
module adcseq_sar #(
   parameter int RES = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic           abort_i,
   input  logic           cmp_i,
   output logic [RES-1:0] code_o,
   output logic           done_o,
   output logic [RES-1:0] res_o
);

   localparam logic [RES-1:0] TOP_BIT = {1'b1, {(RES-1){1'b0}}};

   logic [RES-1:0] trial_q;
   logic [RES-1:0] mark_q;
   logic           active_q;
   logic [RES-1:0] kept;

   // keep the trial bit when the input sits at or above the trial code
   assign kept   = cmp_i ? trial_q : (trial_q & ~mark_q);
   assign done_o = active_q & mark_q[0];
   assign res_o  = kept;
   assign code_o = trial_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trial_q  <= '0;
         mark_q   <= '0;
         active_q <= 1'b0;
      end else if (abort_i) begin
         trial_q  <= '0;
         mark_q   <= '0;
         active_q <= 1'b0;
      end else if (start_i) begin
         trial_q  <= TOP_BIT;
         mark_q   <= TOP_BIT;
         active_q <= 1'b1;
      end else if (active_q) begin
         if (mark_q[0]) begin
            trial_q  <= '0;
            mark_q   <= '0;
            active_q <= 1'b0;
         end else begin
            trial_q <= kept | (mark_q >> 1);
            mark_q  <= mark_q >> 1;
         end
      end
   end

endmodule

// File: rtl/adcseq_rbank.sv
// Per-channel result registers with valid and overrun tracking.
module adcseq_rbank #(
   parameter int NCH = 12,
   parameter int RES = 12,
   parameter int CHW = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en_i,
   input  logic [CHW-1:0] wr_ch_i,
   input  logic [RES-1:0] wr_data_i,
   input  logic           rd_en_i,
   input  logic [CHW-1:0] rd_ch_i,
   output logic [RES-1:0] rd_data_o,
   output logic           rd_vld_o,
   output logic           rd_ovr_o
);

   logic [RES-1:0] data_w [NCH];
   logic [NCH-1:0] vld_w;
   logic [NCH-1:0] ovr_w;

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_slot
         logic [RES-1:0] d_q;
         logic           v_q;
         logic           o_q;
         logic           hit_wr;
         logic           hit_rd;

         assign hit_wr = wr_en_i && (wr_ch_i == CHW'(g));
         assign hit_rd = rd_en_i && (rd_ch_i == CHW'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               d_q <= '0;
               v_q <= 1'b0;
               o_q <= 1'b0;
            end else if (hit_wr) begin
               d_q <= wr_data_i;
               v_q <= 1'b1;
               o_q <= hit_rd ? 1'b0 : (o_q | v_q);
            end else if (hit_rd) begin
               v_q <= 1'b0;
               o_q <= 1'b0;
            end
         end

         assign data_w[g] = d_q;
         assign vld_w[g]  = v_q;
         assign ovr_w[g]  = o_q;
      end
   endgenerate

   always_comb begin
      rd_data_o = '0;
      rd_vld_o  = 1'b0;
      rd_ovr_o  = 1'b0;
      for (int i = 0; i < NCH; i++) begin
         if (rd_ch_i == CHW'(i)) begin
            rd_data_o = data_w[i];
            rd_vld_o  = vld_w[i];
            rd_ovr_o  = ovr_w[i];
         end
      end
   end

endmodule

// File: rtl/adcseq_ctrl.sv
// Scan controller: mode handling and ordered walk over the channel mask.
module adcseq_ctrl
   import adcseq_pkg::*;
#(
   parameter int NCH = 12,
   parameter int CHW = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [1:0]     mode_i,
   input  logic [NCH-1:0] mask_i,
   input  logic           fire_i,
   input  logic           stop_i,
   input  logic           conv_done_i,
   output seq_state_e     state_o,
   output logic [CHW-1:0] ch_o,
   output logic           sar_start_o,
   output logic           wr_en_o,
   output logic           scan_end_o
);

   seq_state_e     state_q, state_d;
   logic [CHW-1:0] ch_q, ch_d;
   logic [CHW-1:0] first_ch, next_ch;
   logic           first_vld, next_vld;
   scan_mode_e     mode;

   assign mode = scan_mode_e'(mode_i);

   adcseq_pick #(.NCH(NCH), .CHW(CHW)) u_pick (
      .mask_i      (mask_i),
      .cur_ch_i    (ch_q),
      .first_ch_o  (first_ch),
      .first_vld_o (first_vld),
      .next_ch_o   (next_ch),
      .next_vld_o  (next_vld)
   );

   always_comb begin
      state_d     = state_q;
      ch_d        = ch_q;
      sar_start_o = 1'b0;
      wr_en_o     = 1'b0;
      scan_end_o  = 1'b0;
      if (stop_i) begin
         state_d = SQ_IDLE;
      end else begin
         case (state_q)
            SQ_IDLE: begin
               if (fire_i && first_vld) begin
                  state_d = SQ_SAMPLE;
                  ch_d    = first_ch;
               end
            end
            SQ_SAMPLE: begin
               state_d     = SQ_CONV;
               sar_start_o = 1'b1;
            end
            SQ_CONV: begin
               if (conv_done_i) begin
                  wr_en_o = 1'b1;
                  if ((mode == MODE_SCAN || mode == MODE_CONT) && next_vld) begin
                     ch_d    = next_ch;
                     state_d = SQ_SAMPLE;
                  end else begin
                     scan_end_o = 1'b1;
                     if (mode == MODE_CONT && first_vld) begin
                        ch_d    = first_ch;
                        state_d = SQ_SAMPLE;
                     end else begin
                        state_d = SQ_IDLE;
                     end
                  end
               end
            end
            default: state_d = SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         ch_q    <= '0;
      end else begin
         state_q <= state_d;
         ch_q    <= ch_d;
      end
   end

   assign state_o = state_q;
   assign ch_o    = ch_q;

endmodule

// File: rtl/adc_scan_seq.sv
// Top level of the scan sequencer.
module adc_scan_seq
   import adcseq_pkg::*;
#(
   parameter int NCH         = 12,
   parameter int RES         = 12,
   parameter int SYNC_STAGES = 2,
   localparam int CHW        = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [1:0]     mode_i,
   input  logic [NCH-1:0] chan_mask_i,
   input  logic           sw_start_i,
   input  logic           ext_start_i,
   input  logic           tmr_evt_i,
   input  logic           pwm_trig_i,
   input  logic [2:0]     hw_trig_en_i,
   input  logic           stop_i,
   input  logic           cmp_i,
   output logic [RES-1:0] dac_code_o,
   output logic           sample_o,
   output logic           busy_o,
   output logic [CHW-1:0] cur_ch_o,
   input  logic           rd_en_i,
   input  logic [CHW-1:0] rd_ch_i,
   output logic [RES-1:0] rd_data_o,
   output logic           rd_valid_o,
   output logic           rd_ovr_o,
   input  logic           eoc_clr_i,
   input  logic           int_en_i,
   output logic           eoc_o,
   output logic           irq_o
);

   generate
      if (NCH < 1 || NCH > 64) begin : g_bad_nch
         $error("adc_scan_seq: NCH out of range");
      end
      if (RES < 2 || RES > 24) begin : g_bad_res
         $error("adc_scan_seq: RES out of range");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("adc_scan_seq: SYNC_STAGES out of range");
      end
   endgenerate

   logic           fire;
   logic           sar_start;
   logic           sar_done;
   logic [RES-1:0] sar_res;
   logic           wr_en;
   logic           scan_end;
   seq_state_e     state;
   logic           eoc_q;

   adcseq_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_start_i (sw_start_i),
      .ext_pin_i  (ext_start_i),
      .tmr_evt_i  (tmr_evt_i),
      .pwm_trig_i (pwm_trig_i),
      .hw_en_i    (hw_trig_en_i),
      .fire_o     (fire)
   );

   adcseq_ctrl #(.NCH(NCH), .CHW(CHW)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_i      (mode_i),
      .mask_i      (chan_mask_i),
      .fire_i      (fire),
      .stop_i      (stop_i),
      .conv_done_i (sar_done),
      .state_o     (state),
      .ch_o        (cur_ch_o),
      .sar_start_o (sar_start),
      .wr_en_o     (wr_en),
      .scan_end_o  (scan_end)
   );

   adcseq_sar #(.RES(RES)) u_sar (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (sar_start),
      .abort_i (stop_i),
      .cmp_i   (cmp_i),
      .code_o  (dac_code_o),
      .done_o  (sar_done),
      .res_o   (sar_res)
   );

   adcseq_rbank #(.NCH(NCH), .RES(RES), .CHW(CHW)) u_rbank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_ch_i   (cur_ch_o),
      .wr_data_i (sar_res),
      .rd_en_i   (rd_en_i),
      .rd_ch_i   (rd_ch_i),
      .rd_data_o (rd_data_o),
      .rd_vld_o  (rd_valid_o),
      .rd_ovr_o  (rd_ovr_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         eoc_q <= 1'b0;
      else if (scan_end)  eoc_q <= 1'b1;
      else if (eoc_clr_i) eoc_q <= 1'b0;
   end

   assign eoc_o    = eoc_q;
   assign irq_o    = eoc_q & int_en_i;
   assign busy_o   = (state != SQ_IDLE);
   assign sample_o = (state == SQ_SAMPLE);

endmodule

// File: rtl/adcseq_chk.sv
// Property checker attached to the sequencer top.
module adcseq_chk #(
   parameter int NCH = 12,
   parameter int RES = 12
) (
   input logic           clk,
   input logic           rst_n,
   input logic           stop_i,
   input logic           eoc_clr_i,
   input logic [NCH-1:0] chan_mask_i,
   input logic           busy_o,
   input logic           sample_o,
   input logic           eoc_o,
   input logic [RES-1:0] dac_code_o
);

   localparam logic [RES-1:0] MSB_ONLY = {1'b1, {(RES-1){1'b0}}};

   assert_sample_one_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sample_o |=> !sample_o);

   assert_msb_trial_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_o && !stop_i) |=> (dac_code_o == MSB_ONLY));

   assert_eoc_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc_o && !eoc_clr_i) |=> eoc_o);

   assert_empty_mask_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && (chan_mask_i == '0)) |=> !busy_o);

   assert_stop_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> !busy_o);

endmodule

bind adc_scan_seq adcseq_chk #(.NCH(NCH), .RES(RES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .stop_i      (stop_i),
   .eoc_clr_i   (eoc_clr_i),
   .chan_mask_i (chan_mask_i),
   .busy_o      (busy_o),
   .sample_o    (sample_o),
   .eoc_o       (eoc_o),
   .dac_code_o  (dac_code_o)
);

// File: tb/adc_scan_seq_test.sv
`timescale 1ns/1ps
module adc_scan_seq_test;

   localparam int NCH = 12;
   localparam int RES = 12;
   localparam int CHW = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [1:0]     mode = 2'd0;
   logic [NCH-1:0] mask = '0;
   logic           sw = 1'b0, ext = 1'b0, tmr = 1'b0, pwm = 1'b0;
   logic [2:0]     hwen = 3'b000;
   logic           stop = 1'b0;
   logic           cmp;
   logic [RES-1:0] dac;
   logic           smp, busy;
   logic [CHW-1:0] cur_ch;
   logic           rd_en = 1'b0;
   logic [CHW-1:0] rd_ch = '0;
   logic [RES-1:0] rd_data;
   logic           rd_vld, rd_ovr;
   logic           eoc_clr = 1'b0, int_en = 1'b0;
   logic           eoc, irq;

   logic [RES-1:0] vin [16];
   int nchk = 0;
   int nfail = 0;
   int busy_cnt = 0;
   int seq_n = 0;
   int seq_log [64];

   always #2 clk = ~clk;

   // comparator model: input at or above trial code
   assign cmp = (vin[cur_ch] >= dac);

   adc_scan_seq uut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .chan_mask_i(mask),
      .sw_start_i(sw), .ext_start_i(ext), .tmr_evt_i(tmr), .pwm_trig_i(pwm),
      .hw_trig_en_i(hwen), .stop_i(stop), .cmp_i(cmp), .dac_code_o(dac),
      .sample_o(smp), .busy_o(busy), .cur_ch_o(cur_ch), .rd_en_i(rd_en),
      .rd_ch_i(rd_ch), .rd_data_o(rd_data), .rd_valid_o(rd_vld), .rd_ovr_o(rd_ovr),
      .eoc_clr_i(eoc_clr), .int_en_i(int_en), .eoc_o(eoc), .irq_o(irq)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (busy) busy_cnt++;
         if (smp && seq_n < 64) begin
            seq_log[seq_n] = int'(cur_ch);
            seq_n++;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic clear_logs();
      busy_cnt = 0;
      seq_n = 0;
   endtask

   task automatic pulse_sw();
      @(negedge clk); sw = 1'b1;
      @(negedge clk); sw = 1'b0;
   endtask

   task automatic wait_idle(input string tag);
      int n;
      n = 0;
      while (busy && n < 3000) begin
         @(negedge clk);
         n++;
      end
      if (busy) chk(1'b0, {tag, " timeout waiting idle"}, n, 3000);
   endtask

   task automatic read_ch(input int ch, input bit clr,
                          output int data, output bit v, output bit o);
      @(negedge clk);
      rd_ch = CHW'(ch);
      #1;
      data = int'(rd_data);
      v = rd_vld;
      o = rd_ovr;
      if (clr) begin
         rd_en = 1'b1;
         @(negedge clk);
         rd_en = 1'b0;
      end
   endtask

   task automatic drain_all();
      int d; bit v, o;
      for (int c = 0; c < NCH; c++) read_ch(c, 1'b1, d, v, o);
   endtask

   task automatic clear_eoc();
      @(negedge clk); eoc_clr = 1'b1;
      @(negedge clk); eoc_clr = 1'b0;
   endtask

   function automatic int popc(input logic [NCH-1:0] m);
      int n = 0;
      for (int i = 0; i < NCH; i++) if (m[i]) n++;
      return n;
   endfunction

   task automatic check_order(input logic [NCH-1:0] m, input string tag);
      int idx;
      idx = 0;
      for (int i = 0; i < NCH; i++) begin
         if (m[i]) begin
            chk(seq_log[idx] == i, tag, seq_log[idx], i);
            idx++;
         end
      end
      chk(seq_n == idx, {tag, " count"}, seq_n, idx);
   endtask

   task automatic check_bank(input logic [NCH-1:0] m, input string tag);
      int d; bit v, o;
      for (int c = 0; c < NCH; c++) begin
         read_ch(c, 1'b1, d, v, o);
         if (m[c]) begin
            chk(v == 1'b1, {tag, " R9 valid"}, v, 1);
            chk(d == int'(vin[c]), {tag, " R1 data"}, d, int'(vin[c]));
         end else begin
            chk(v == 1'b0, {tag, " R3 unmasked not written"}, v, 0);
         end
      end
   endtask

   initial begin
      #(4 * 150000);
      nfail++;
      $display("FAIL watchdog act=%0d exp=%0d", 150000, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      int d; bit v, o;
      void'($urandom(32'd1457));
      for (int i = 0; i < 16; i++) vin[i] = RES'($urandom);
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // reset state
      chk(busy == 0 && smp == 0, "R2 reset idle", busy, 0);
      chk(eoc == 0 && irq == 0, "R8 reset flag", eoc, 0);
      chk(dac == 0, "R1 reset dac", int'(dac), 0);
      read_ch(0, 1'b0, d, v, o);
      chk(v == 0 && o == 0, "R9 reset valid", v, 0);

      // single mode on lowest enabled channel, timing and first trial
      mode = 2'd0; mask = 12'h028; vin[3] = 12'hABC; int_en = 1'b1;
      clear_logs();
      pulse_sw();
      chk(smp == 1, "R2 sample after trigger", smp, 1);
      tick(1);
      chk(smp == 0, "R2 sample one clock", smp, 0);
      chk(dac == 12'h800, "R2 first trial msb", int'(dac), 'h800);
      wait_idle("R4");
      chk(busy_cnt == 13, "R2 busy clocks single", busy_cnt, 13);
      chk(seq_n == 1 && seq_log[0] == 3, "R4 single lowest channel", seq_log[0], 3);
      chk(eoc == 1, "R8 eoc set", eoc, 1);
      chk(irq == 1, "R8 irq enabled", irq, 1);
      read_ch(3, 1'b0, d, v, o);
      chk(v == 1 && d == 'hABC, "R1 single result", d, 'hABC);
      read_ch(5, 1'b0, d, v, o);
      chk(v == 0, "R4 second channel untouched", v, 0);
      int_en = 1'b0; #1;
      chk(irq == 0, "R8 irq masked", irq, 0);
      tick(5);
      chk(eoc == 1, "R8 eoc sticky", eoc, 1);
      clear_eoc();
      chk(eoc == 0, "R8 eoc cleared", eoc, 0);
      drain_all();
      read_ch(3, 1'b0, d, v, o);
      chk(v == 0 && o == 0, "R9 read clears valid", v, 0);

      // code range ends, highest channel
      mode = 2'd1; mask = 12'h801; vin[0] = 12'h000; vin[11] = 12'hFFF;
      clear_logs();
      pulse_sw();
      wait_idle("R1");
      check_order(mask, "R3 ends order");
      check_bank(mask, "R1 ends");
      clear_eoc();

      // empty mask
      mask = '0; clear_logs();
      pulse_sw(); tick(20);
      chk(busy_cnt == 0, "R7 empty mask no conversion", busy_cnt, 0);
      chk(eoc == 0, "R7 empty mask no eoc", eoc, 0);

      // trigger while busy is ignored
      mask = 12'h060; clear_logs();
      pulse_sw(); tick(6); pulse_sw();
      wait_idle("R7"); tick(30);
      chk(busy_cnt == 26, "R7 retrigger ignored", busy_cnt, 26);
      check_order(mask, "R3 two channel order");
      drain_all(); clear_eoc();

      // hardware sources disabled
      mode = 2'd0; mask = 12'h004; hwen = 3'b000; clear_logs();
      @(negedge clk); tmr = 1; pwm = 1; ext = 1;
      @(negedge clk); tmr = 0; pwm = 0;
      tick(20); ext = 0; tick(5);
      chk(busy_cnt == 0, "R6 disabled sources", busy_cnt, 0);
      // each source enabled alone
      for (int s = 0; s < 3; s++) begin
         hwen = 3'(1 << s); clear_logs();
         @(negedge clk);
         if (s == 0) ext = 1; else if (s == 1) tmr = 1; else pwm = 1;
         @(negedge clk); tmr = 0; pwm = 0;
         tick(5);
         wait_idle("R6");
         ext = 0; tick(4);
         chk(busy_cnt == 13, "R6 enabled source starts", busy_cnt, 13);
      end
      hwen = 3'b000;
      drain_all(); clear_eoc();

      // continuous mode, overrun, stop
      mode = 2'd2; mask = 12'h006; clear_logs();
      pulse_sw();
      begin
         int n;
         n = 0;
         while (seq_n < 6 && n < 500) begin tick(1); n++; end
      end
      @(negedge clk); stop = 1'b1;
      @(negedge clk); stop = 1'b0;
      chk(busy == 0, "R10 stop to idle", busy, 0);
      for (int k = 0; k < 6; k++)
         chk(seq_log[k] == 1 + (k % 2), "R5 continuous wrap order", seq_log[k], 1 + (k % 2));
      clear_logs(); tick(30);
      chk(busy_cnt == 0, "R5 stays stopped", busy_cnt, 0);
      read_ch(1, 1'b0, d, v, o);
      chk(o == 1 && v == 1, "R9 overrun set", o, 1);
      chk(d == int'(vin[1]), "R1 continuous data", d, int'(vin[1]));
      read_ch(1, 1'b1, d, v, o);
      read_ch(1, 1'b0, d, v, o);
      chk(v == 0 && o == 0, "R9 overrun cleared by read", o, 0);
      drain_all(); clear_eoc();

      // stop in the middle of a conversion
      mode = 2'd0; mask = 12'h010; clear_logs();
      pulse_sw(); tick(5);
      @(negedge clk); stop = 1'b1;
      @(negedge clk); stop = 1'b0;
      tick(20);
      read_ch(4, 1'b0, d, v, o);
      chk(v == 0, "R10 aborted channel not written", v, 0);
      chk(eoc == 0, "R10 abort sets no eoc", eoc, 0);

      // random scans
      for (int it = 0; it < 20; it++) begin
         logic [NCH-1:0] m;
         m = NCH'($urandom);
         if (m == '0) m = 12'h100;
         for (int i = 0; i < 16; i++) vin[i] = RES'($urandom);
         mode = 2'd1; mask = m; clear_logs();
         pulse_sw();
         wait_idle("R3");
         chk(busy_cnt == 13 * popc(m), "R2 scan busy clocks", busy_cnt, 13 * popc(m));
         check_order(m, "R3 random order");
         check_bank(m, "R3 random");
         clear_eoc();
      end

      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule